// File: doc/BRIEF.md
# Latency-Table Issue Interlock

This block sits at the issue point of an in-order, single-issue pipelined core that has an integer and a floating-point register file. Each cycle at most one decoded instruction is offered on a valid/ready input: an operation class, an optional destination register and up to two optional source registers. The block keeps a scoreboard with one entry per architectural register. Each entry holds the kind of the last producer and a saturating count of the cycles elapsed since that producer issued.

A source is blocked while the number of intervening cycles since its producer issued is below the gap in a fixed latency table. That gap depends on both the producer kind and the role the source plays in the consumer. While any source is blocked the block raises `stall` and drops `in_ready`, and the upstream stage must hold the instruction unchanged. A free-running cycle counter is exported. Its value in the cycle where `issue` is high is that instruction's issue cycle, so stall counts of whole code sequences can be measured.

Back-pressure rules: an instruction issues in a cycle where `in_valid` and `in_ready` are both high. `in_ready` is low only while a dependence is unsatisfied. The offered fields must stay stable until issue.

Top module: `ilk_issue_interlock`

## Requirements
- R1: During and directly after synchronous active-high reset, `cycle_count` is 0, `stall` is low and every register is free, so the first instruction issues without stalling.
- R2: `stall` is high only when `in_valid` is high and a source is blocked. `in_ready` is the inverse of `stall`. `issue` is high for one cycle when the instruction is taken. A consumer that needs a gap of N intervening cycles sees exactly N stalled cycles. Class codes: 0 integer ALU, 1 integer load, 2 FP ALU, 3 FP load, 4 store, 5 branch, 6 no-op.
- R3: An FP ALU result read by an FP ALU operation needs 3 intervening cycles, so the consumer issues 4 cycles after the producer.
- R4: An FP ALU result used as store data needs 2 intervening cycles.
- R5: An FP load result needs 1 intervening cycle before an FP ALU use and 0 before a use as store data.
- R6: An integer load result needs 1 intervening cycle before an integer ALU use. An integer ALU result needs 0.
- R7: A branch reading an integer ALU result needs 1 intervening cycle.
- R8: For a store, source A is the base address and follows general integer rules (0 after an integer ALU op, 1 after an integer load). Source B is the data and follows the store-data rules.
- R9: Integer register 0 (index 0) is never marked busy. A store, branch, no-op, or any instruction with `in_dst_en` low, updates no scoreboard entry.
- R10: `cycle_count` increases by one every clock after reset.
- R11: Load, FP add, store, decrement, branch (chained) issues over 9 cycles. The reordered form (load, decrement, add, store, branch) takes 7. A four-way unrolled and reordered 14-instruction body takes 14 cycles.
- R12: Instructions with no pending dependence issue on consecutive cycles without stalls.
- R13: Register operands are 6 bits. Bit 5 selects the FP file (1) or the integer file (0), and bits 4:0 give the register number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Instruction may issue this cycle |
| in_cls | input | 3 | Operation class code |
| in_dst_en | input | 1 | Destination present |
| in_dst | input | 6 | Destination register |
| in_sa_en | input | 1 | Source A present |
| in_sa | input | 6 | Source A (store: base address) |
| in_sb_en | input | 1 | Source B present |
| in_sb | input | 6 | Source B (store: data) |
| stall | output | 1 | Dependence unsatisfied; hold instruction |
| issue | output | 1 | Instruction taken this cycle |
| cycle_count | output | 16 | Free-running cycle counter |

## Verification
A wrong producer kind or elapsed count in a scoreboard entry shows up when the next consumer of that register arrives. That consumer issues early or late, so the difference between its `cycle_count` stamp and its producer's stamp moves off the table value, and the number of `stall` cycles changes with it. An entry that is written when it should not be, such as integer register 0 or a store destination, causes an unexpected stall on the very next reader. The chained, reordered and unrolled sequences combine several table cells and roles in one run, so a single wrong cell changes their total cycle counts.

// File: rtl/ilk_pkg.sv
package ilk_pkg;

  typedef enum logic [2:0] {
    OP_IALU   = 3'd0,
    OP_ILOAD  = 3'd1,
    OP_FALU   = 3'd2,
    OP_FLOAD  = 3'd3,
    OP_STORE  = 3'd4,
    OP_BRANCH = 3'd5,
    OP_NOP    = 3'd6
  } op_cls_e;

  typedef enum logic [1:0] {
    PK_IALU  = 2'd0,
    PK_ILOAD = 2'd1,
    PK_FALU  = 2'd2,
    PK_FLOAD = 2'd3
  } prod_e;

  typedef enum logic [1:0] {
    RL_GEN   = 2'd0,
    RL_FP    = 2'd1,
    RL_SDATA = 2'd2,
    RL_BR    = 2'd3
  } role_e;

  localparam int MAX_GAP = 3;
  localparam int AGE_W   = $clog2(MAX_GAP + 1);

  // Intervening cycles a consumer in role r needs after a producer of kind p.
  function automatic logic [AGE_W-1:0] gap_of(prod_e p, role_e r);
    logic [AGE_W-1:0] g;
    case (p)
      PK_IALU:  g = (r == RL_BR) ? AGE_W'(1) : AGE_W'(0);
      PK_ILOAD: g = (r == RL_SDATA) ? AGE_W'(0) : AGE_W'(1);
      PK_FALU:  g = (r == RL_SDATA) ? AGE_W'(2) : AGE_W'(3);
      default:  g = (r == RL_SDATA) ? AGE_W'(0) : AGE_W'(1);
    endcase
    return g;
  endfunction

  function automatic logic writes_reg(logic [2:0] c);
    return (c == OP_IALU) || (c == OP_ILOAD) || (c == OP_FALU) || (c == OP_FLOAD);
  endfunction

  function automatic prod_e kind_of(logic [2:0] c);
    case (c)
      OP_ILOAD: return PK_ILOAD;
      OP_FALU:  return PK_FALU;
      OP_FLOAD: return PK_FLOAD;
      default:  return PK_IALU;
    endcase
  endfunction

endpackage

// File: rtl/ilk_scoreboard.sv
module ilk_scoreboard
  import ilk_pkg::*;
#(
  parameter int NREG  = 64,
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  prod_e            wr_kind,
  input  logic [IDX_W-1:0] rd_idx [2],
  output prod_e            rd_kind [2],
  output logic [AGE_W-1:0] rd_age [2]
);

  prod_e            kind_q [NREG];
  logic [AGE_W-1:0] age_q  [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_ent
    always_ff @(posedge clk) begin
      if (rst) begin
        kind_q[i] <= PK_IALU;
        age_q[i]  <= '1;
      end else if (wr_en && (wr_idx == IDX_W'(i))) begin
        kind_q[i] <= wr_kind;
        age_q[i]  <= '0;
      end else if (age_q[i] != '1) begin
        age_q[i] <= age_q[i] + 1'b1;
      end
    end
  end

  for (genvar s = 0; s < 2; s++) begin : g_rd
    assign rd_kind[s] = kind_q[rd_idx[s]];
    assign rd_age[s]  = age_q[rd_idx[s]];
  end

endmodule

// File: rtl/ilk_src_gate.sv
module ilk_src_gate
  import ilk_pkg::*;
(
  input  logic             src_en,
  input  role_e            role,
  input  prod_e            kind,
  input  logic [AGE_W-1:0] age,
  output logic             blocked
);

  always_comb begin
    blocked = src_en && (age < gap_of(kind, role));
  end

endmodule

// File: rtl/ilk_issue_interlock.sv
module ilk_issue_interlock
  import ilk_pkg::*;
#(
  parameter int REGS_PER_FILE = 32,
  parameter int CYC_W         = 16,
  localparam int IDX_W        = $clog2(REGS_PER_FILE) + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [2:0]       in_cls,
  input  logic             in_dst_en,
  input  logic [IDX_W-1:0] in_dst,
  input  logic             in_sa_en,
  input  logic [IDX_W-1:0] in_sa,
  input  logic             in_sb_en,
  input  logic [IDX_W-1:0] in_sb,
  output logic             stall,
  output logic             issue,
  output logic [CYC_W-1:0] cycle_count
);

  localparam int NREG = 2 * REGS_PER_FILE;

  logic [IDX_W-1:0] rd_idx  [2];
  prod_e            rd_kind [2];
  logic [AGE_W-1:0] rd_age  [2];
  logic             src_en  [2];
  role_e            role    [2];
  logic [1:0]       blk;
  logic             wr_en;

  // Roles: source A is a store's base address, source B its data.
  always_comb begin
    rd_idx[0] = in_sa;
    rd_idx[1] = in_sb;
    src_en[0] = in_sa_en;
    src_en[1] = in_sb_en;
    case (in_cls)
      OP_FALU:   begin role[0] = RL_FP;  role[1] = RL_FP;    end
      OP_BRANCH: begin role[0] = RL_BR;  role[1] = RL_BR;    end
      OP_STORE:  begin role[0] = RL_GEN; role[1] = RL_SDATA; end
      default:   begin role[0] = RL_GEN; role[1] = RL_GEN;   end
    endcase
  end

  for (genvar s = 0; s < 2; s++) begin : g_src
    ilk_src_gate u_gate (
      .src_en  (src_en[s]),
      .role    (role[s]),
      .kind    (rd_kind[s]),
      .age     (rd_age[s]),
      .blocked (blk[s])
    );
  end

  assign stall    = in_valid && (|blk);
  assign in_ready = !stall;
  assign issue    = in_valid && in_ready;
  assign wr_en    = issue && in_dst_en && writes_reg(in_cls) && (in_dst != '0);

  ilk_scoreboard #(
    .NREG  (NREG),
    .IDX_W (IDX_W)
  ) u_sb (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_idx  (in_dst),
    .wr_kind (kind_of(in_cls)),
    .rd_idx  (rd_idx),
    .rd_kind (rd_kind),
    .rd_age  (rd_age)
  );

  always_ff @(posedge clk) begin
    if (rst) cycle_count <= '0;
    else     cycle_count <= cycle_count + 1'b1;
  end

endmodule

// File: rtl/ilk_issue_interlock_chk.sv
module ilk_issue_interlock_chk #(
  parameter int IDX_W = 6,
  parameter int CYC_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_ready,
  input logic [2:0]       in_cls,
  input logic             in_dst_en,
  input logic [IDX_W-1:0] in_dst,
  input logic             in_sa_en,
  input logic [IDX_W-1:0] in_sa,
  input logic             in_sb_en,
  input logic [IDX_W-1:0] in_sb,
  input logic             stall,
  input logic             issue,
  input logic [CYC_W-1:0] cycle_count
);

  // R2
  stall_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
    stall |-> (in_valid && !in_ready));

  // R10
  cycle_step_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (cycle_count == $past(cycle_count) + 1'b1));

  // R3
  fp_chain_chk: assert property (@(posedge clk) disable iff (rst)
    (issue && in_cls == 3'd2 && in_dst_en && in_dst != '0) |=>
      ((in_valid && in_cls == 3'd2 && in_sa_en && in_sa == $past(in_dst)) |-> stall));

  // R9
  zero_reg_chk: assert property (@(posedge clk) disable iff (rst)
    (issue && in_dst_en && in_dst == '0) |=>
      ((in_valid && in_sa_en && in_sa == '0 && !in_sb_en) |-> !stall));

endmodule

bind ilk_issue_interlock ilk_issue_interlock_chk #(
  .IDX_W (IDX_W),
  .CYC_W (CYC_W)
) u_chk (.*);

// File: tb/tb_ilk_issue_interlock.sv
module tb_ilk_issue_interlock;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [2:0] in_cls = 3'd6;
  logic       in_dst_en = 1'b0;
  logic [5:0] in_dst = '0;
  logic       in_sa_en = 1'b0;
  logic [5:0] in_sa = '0;
  logic       in_sb_en = 1'b0;
  logic [5:0] in_sb = '0;
  logic       stall, issue;
  logic [15:0] cycle_count;

  int vecs = 0;
  int errs = 0;
  bit done = 0;

  localparam logic [2:0] IALU = 3'd0, ILD = 3'd1, FALU = 3'd2, FLD = 3'd3,
                         ST = 3'd4, BR = 3'd5;
  localparam logic [5:0] X0 = 6'd0, X1 = 6'd1, X2 = 6'd2, X3 = 6'd3;

  function automatic logic [5:0] fr(int n);
    return 6'h20 + 6'(n);
  endfunction

  always #5 clk = ~clk;

  ilk_issue_interlock dut (.*);

  task automatic chk(bit ok, string req, int act, int exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic send(logic [2:0] c, logic de, logic [5:0] d, logic ae, logic [5:0] a,
                      logic be, logic [5:0] b, output int stamp, output int stalls);
    stalls = 0;
    in_valid = 1; in_cls = c; in_dst_en = de; in_dst = d;
    in_sa_en = ae; in_sa = a; in_sb_en = be; in_sb = b;
    #1;
    while (!in_ready) begin
      if (!stall) chk(0, "R2", 0, 1);
      stalls++;
      @(negedge clk); #1;
    end
    stamp = int'(cycle_count);
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic pair(string req, logic [2:0] pc, logic [5:0] pd,
                      logic [2:0] cc, logic ae, logic [5:0] a, logic be, logic [5:0] b,
                      int gap);
    int s0, s1, n0, n1;
    idle(5);
    send(pc, 1, pd, 0, X0, 0, X0, s0, n0);
    send(cc, 0, X0, ae, a, be, b, s1, n1);
    chk(s1 - s0 == gap + 1, req, s1 - s0, gap + 1);
    chk(n1 == gap, "R2", n1, gap);
  endtask

  task automatic t_reset();
    idle(2);
    chk(cycle_count == 0, "R1", cycle_count, 0);
    chk(stall == 0, "R1", stall, 0);
    rst = 0;
    @(negedge clk);
    chk(cycle_count == 1, "R1", cycle_count, 1);
    in_valid = 1; in_cls = FALU; in_sa_en = 1; in_sa = fr(6); in_sb_en = 1; in_sb = fr(7);
    #1;
    chk(in_ready == 1, "R1", in_ready, 1);
    in_valid = 0; in_sa_en = 0; in_sb_en = 0;
    #1;
    chk(stall == 0 && issue == 0, "R2", stall, 0);
  endtask

  task automatic t_count();
    int a;
    @(negedge clk); a = int'(cycle_count);
    idle(7);
    chk(int'(cycle_count) - a == 7, "R10", int'(cycle_count) - a, 7);
  endtask

  task automatic t_table();
    pair("R3", FALU, fr(4), FALU, 1, fr(4), 1, fr(2), 3);
    pair("R4", FALU, fr(4), ST, 1, X1, 1, fr(4), 2);
    pair("R5", FLD, fr(0), FALU, 1, fr(0), 0, X0, 1);
    pair("R5", FLD, fr(0), ST, 1, X1, 1, fr(0), 0);
    pair("R6", ILD, X3, IALU, 1, X3, 0, X0, 1);
    pair("R6", IALU, X3, IALU, 0, X0, 1, X3, 0);
    pair("R7", IALU, X1, BR, 1, X1, 1, X2, 1);
    pair("R8", IALU, X1, ST, 1, X1, 1, fr(9), 0);
    pair("R8", ILD, X1, ST, 1, X1, 1, fr(9), 1);
    pair("R13", FALU, fr(5), IALU, 1, 6'd5, 0, X0, 0);
  endtask

  task automatic t_ignore();
    int s0, s1, n0, n1;
    pair("R9", ILD, X0, IALU, 1, X0, 0, X0, 0);
    idle(5);
    send(ST, 1, fr(2), 1, X1, 1, fr(3), s0, n0);
    send(FALU, 0, X0, 1, fr(2), 0, X0, s1, n1);
    chk(n1 == 0, "R9", n1, 0);
    idle(5);
    send(FALU, 0, fr(8), 0, X0, 0, X0, s0, n0);
    send(FALU, 0, X0, 1, fr(8), 0, X0, s1, n1);
    chk(n1 == 0, "R9", n1, 0);
  endtask

  task automatic t_indep();
    int s [4];
    int n [4];
    int tot = 0;
    idle(5);
    for (int i = 0; i < 4; i++) begin
      send(FALU, 1, fr(10 + i), 1, fr(20 + i), 0, X0, s[i], n[i]);
      tot += n[i];
    end
    chk(s[3] - s[0] == 3, "R12", s[3] - s[0], 3);
    chk(tot == 0, "R12", tot, 0);
  endtask

  task automatic t_seq_plain();
    int s0, sx, n;
    idle(5);
    send(FLD, 1, fr(0), 1, X1, 0, X0, s0, n);
    send(FALU, 1, fr(4), 1, fr(0), 1, fr(2), sx, n);
    send(ST, 0, X0, 1, X1, 1, fr(4), sx, n);
    send(IALU, 1, X1, 1, X1, 0, X0, sx, n);
    send(BR, 0, X0, 1, X1, 1, X2, sx, n);
    chk(sx - s0 + 1 == 9, "R11", sx - s0 + 1, 9);
  endtask

  task automatic t_seq_sched();
    int s0, sx, n;
    idle(5);
    send(FLD, 1, fr(0), 1, X1, 0, X0, s0, n);
    send(IALU, 1, X1, 1, X1, 0, X0, sx, n);
    send(FALU, 1, fr(4), 1, fr(0), 1, fr(2), sx, n);
    send(ST, 0, X0, 1, X1, 1, fr(4), sx, n);
    send(BR, 0, X0, 1, X1, 1, X2, sx, n);
    chk(sx - s0 + 1 == 7, "R11", sx - s0 + 1, 7);
  endtask

  task automatic t_seq_unroll();
    int s0, sx, n;
    int tot = 0;
    idle(5);
    send(FLD, 1, fr(0), 1, X1, 0, X0, s0, n); tot += n;
    for (int i = 1; i < 4; i++) begin
      send(FLD, 1, fr(4 * i + 2), 1, X1, 0, X0, sx, n); tot += n;
    end
    send(FALU, 1, fr(4), 1, fr(0), 1, fr(2), sx, n); tot += n;
    for (int i = 1; i < 4; i++) begin
      send(FALU, 1, fr(4 * i + 4), 1, fr(4 * i + 2), 1, fr(2), sx, n); tot += n;
    end
    send(ST, 0, X0, 1, X1, 1, fr(4), sx, n); tot += n;
    send(ST, 0, X0, 1, X1, 1, fr(8), sx, n); tot += n;
    send(IALU, 1, X1, 1, X1, 0, X0, sx, n); tot += n;
    send(ST, 0, X0, 1, X1, 1, fr(12), sx, n); tot += n;
    send(ST, 0, X0, 1, X1, 1, fr(16), sx, n); tot += n;
    send(BR, 0, X0, 1, X1, 1, X2, sx, n); tot += n;
    chk(sx - s0 + 1 == 14, "R11", sx - s0 + 1, 14);
    chk(tot == 0, "R11", tot, 0);
  endtask

  initial begin
    t_reset();
    t_count();
    t_table();
    t_ignore();
    t_indep();
    t_seq_plain();
    t_seq_sched();
    t_seq_unroll();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      vecs++;
      errs++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

endmodule